// File: doc/BRIEF.md
# Debug Event Gating and Status Unit

This unit sits next to a small processor core. It receives raw hit pulses from four instruction-address comparators, two data-address comparators and two data-value comparators. It decides whether each hit becomes a recorded debug event or a halt request for an attached hardware debugger, and whether the recorded events raise a debug interrupt to the core.

Three registers hold the unit's state, reached through a simple register port:

- A control word with an internal-debug enable, an external-debug enable and a per-resource enable mask.
- An ownership word that marks which resources belong to software.
- A sticky event-status word with one flag per source. Flags are cleared by writing ones.

A write flag on the port marks accesses that come from the hardware debugger. While external debug is on, all other writes are dropped.

Comparisons are made on effective addresses only. The comparators themselves are outside this unit; it only qualifies their hits.

Top module: `dbg_event_gate`

## Requirements
- R1: After reset all three registers read zero and both `dbg_irq_o` and `halt_req_o` are low.
- R2: With internal and external debug both off, no hit sets a status flag or raises `halt_req_o`, and flags already set keep their value.
- R3: With internal debug on, a hit on an enabled resource whose software path is live sets its status flag on the next clock edge. The flag order is: instruction-address hits bits 3:0, data-address hits bits 5:4, data-value hits bits 7:6. A hit on a resource whose enable bit is 0 is not recorded.
- R4: `dbg_irq_o` is registered. One cycle after the inputs, it is high when `msr_de_i` and internal debug are on and at least one set flag belongs to a software-owned resource.
- R5: `dbg_irq_o` stays low whenever internal debug is off. It also stays low when external debug is on and the ownership word is zero, whatever the status word holds.
- R6: While external debug is on, writes with `reg_host_i` low change no register. Writes with `reg_host_i` high are always applied.
- R7: While external debug is on, ownership bit 1 gives a resource to software and 0 gives it to the debugger. An enabled hit on a debugger-owned resource pulses `halt_req_o` for one cycle after the hit and sets no status flag. With external debug off, every resource counts as software-owned.
- R8: Writing a 1 to a status bit clears that flag. When a recorded hit lands in the same cycle as the clear, the flag stays set.
- R9: The register map is fixed as follows:
  - Address 0 is control: bit 0 is the internal enable, bit 1 is the external enable, and bits 15:8 are the resource enables.
  - Address 1 is ownership, in bits 7:0.
  - Address 2 is status, in bits 7:0.
  - Address 3 reads zero.
  - Unused bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iac_hit_i | input | 4 | Instruction-address comparator hits |
| dac_hit_i | input | 2 | Data-address comparator hits |
| dvc_hit_i | input | 2 | Data-value comparator hits |
| msr_de_i | input | 1 | Debug-interrupt enable from machine state |
| reg_we_i | input | 1 | Register write strobe |
| reg_host_i | input | 1 | Access comes from the hardware debugger |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data (combinational) |
| dbg_irq_o | output | 1 | Debug interrupt level |
| halt_req_o | output | 1 | One-cycle halt request to the debugger |

## Verification
A wrong flag shows up on the status read one cycle after the hit or clear that caused it. It shows up on `dbg_irq_o` one cycle later still, because the interrupt is computed from the registered status.

A wrong ownership or enable decode shows up as a halt pulse or a status flag on the wrong path, in the cycle right after the hit. A lock fault shows up on the control or ownership read right after the dropped write.

Random traffic with host and software writes mixed in reaches these states quickly. Every cycle compares all three reads and both outputs.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
    localparam int REG_W       = 32;
    localparam int CTRL_INT    = 0;
    localparam int CTRL_EXT    = 1;
    localparam int CTRL_EN_LSB = 8;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_OWN  = 2'd1,
        RA_STAT = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/dbg_gate_regs.sv
module dbg_gate_regs
    import dbg_gate_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic             host_i,
    input  logic [1:0]       addr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic             int_en_o,
    output logic             ext_en_o,
    output logic [NSRC-1:0]  res_en_o,
    output logic [NSRC-1:0]  own_o,
    output logic [NSRC-1:0]  clr_mask_o
);
    typedef struct packed {
        logic            int_en;
        logic            ext_en;
        logic [NSRC-1:0] res_en;
        logic [NSRC-1:0] own;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic accept;

    always_comb begin
        cfg_d      = cfg_q;
        clr_mask_o = '0;
        accept     = we_i && (host_i || !cfg_q.ext_en);
        if (accept) begin
            case (reg_addr_e'(addr_i))
                RA_CTRL: begin
                    cfg_d.int_en = wdata_i[CTRL_INT];
                    cfg_d.ext_en = wdata_i[CTRL_EXT];
                    cfg_d.res_en = wdata_i[CTRL_EN_LSB +: NSRC];
                end
                RA_OWN:  cfg_d.own = wdata_i[NSRC-1:0];
                RA_STAT: clr_mask_o = wdata_i[NSRC-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign int_en_o = cfg_q.int_en;
    assign ext_en_o = cfg_q.ext_en;
    assign res_en_o = cfg_q.res_en;
    assign own_o    = cfg_q.own;

    // Software writes are dropped while external debug holds the block
    assert_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !host_i && ext_en_o) |=> $stable(cfg_q));
endmodule

// File: rtl/dbg_gate_events.sv
module dbg_gate_events #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] hit_i,
    input  logic            int_en_i,
    input  logic            ext_en_i,
    input  logic [NSRC-1:0] res_en_i,
    input  logic [NSRC-1:0] own_i,
    input  logic [NSRC-1:0] clr_mask_i,
    input  logic            irq_en_i,
    output logic [NSRC-1:0] status_o,
    output logic            irq_o,
    output logic            halt_o
);
    typedef struct packed {
        logic [NSRC-1:0] status;
        logic            irq;
        logic            halt;
    } ev_t;

    ev_t ev_d, ev_q;
    logic [NSRC-1:0] sw_own, live, rec, hw_hit;
    logic            gate;

    always_comb begin
        sw_own = ext_en_i ? own_i : {NSRC{1'b1}};
        live   = hit_i & res_en_i;
        rec    = live & sw_own & {NSRC{int_en_i}};
        hw_hit = live & ~sw_own;
        gate   = irq_en_i && int_en_i && (!ext_en_i || (|own_i));

        ev_d.status = (ev_q.status & ~clr_mask_i) | rec;
        ev_d.irq    = gate && (|(ev_q.status & sw_own));
        ev_d.halt   = |hw_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign status_o = ev_q.status;
    assign irq_o    = ev_q.irq;
    assign halt_o   = ev_q.halt;

    assert_no_new_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en_i |=> ((ev_q.status & ~$past(ev_q.status)) == '0));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(ev_q.status & ~clr_mask_i) & ~ev_q.status) == '0));

    assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_en_i || (ext_en_i && own_i == '0)) |=> !ev_q.irq);

    assert_halt_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en_i |=> !ev_q.halt);
endmodule

// File: rtl/dbg_event_gate.sv
module dbg_event_gate
    import dbg_gate_pkg::*;
#(
    parameter int NUM_IAC = 4,
    parameter int NUM_DAC = 2,
    parameter int NUM_DVC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IAC-1:0] iac_hit_i,
    input  logic [NUM_DAC-1:0] dac_hit_i,
    input  logic [NUM_DVC-1:0] dvc_hit_i,
    input  logic               msr_de_i,
    input  logic               reg_we_i,
    input  logic               reg_host_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    output logic               dbg_irq_o,
    output logic               halt_req_o
);
    localparam int NSRC = NUM_IAC + NUM_DAC + NUM_DVC;

    logic            int_en, ext_en;
    logic [NSRC-1:0] res_en, own, clr_mask, status, hits;

    assign hits = {dvc_hit_i, dac_hit_i, iac_hit_i};

    dbg_gate_regs #(.NSRC(NSRC)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (reg_we_i),
        .host_i     (reg_host_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .int_en_o   (int_en),
        .ext_en_o   (ext_en),
        .res_en_o   (res_en),
        .own_o      (own),
        .clr_mask_o (clr_mask)
    );

    dbg_gate_events #(.NSRC(NSRC)) u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hits),
        .int_en_i   (int_en),
        .ext_en_i   (ext_en),
        .res_en_i   (res_en),
        .own_i      (own),
        .clr_mask_i (clr_mask),
        .irq_en_i   (msr_de_i),
        .status_o   (status),
        .irq_o      (dbg_irq_o),
        .halt_o     (halt_req_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_e'(reg_addr_i))
            RA_CTRL: begin
                reg_rdata_o[CTRL_INT]              = int_en;
                reg_rdata_o[CTRL_EXT]              = ext_en;
                reg_rdata_o[CTRL_EN_LSB +: NSRC]   = res_en;
            end
            RA_OWN:  reg_rdata_o[NSRC-1:0] = own;
            RA_STAT: reg_rdata_o[NSRC-1:0] = status;
            default: reg_rdata_o = '0;
        endcase
    end

    // Reset leaves every output quiet (R1)
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!dbg_irq_o && !halt_req_o));
endmodule

// File: tb/dbg_event_gate_test.sv
module dbg_event_gate_test;
    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  iac = '0;
    logic [1:0]  dac = '0, dvc = '0;
    logic        de = 1'b0, we = 1'b0, host = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wd = '0;
    logic [31:0] rdata;
    logic        irq, halt;

    int errors = 0;
    int checks = 0;

    bit       m_int, m_ext, e_irq, e_halt;
    bit [7:0] m_en, m_own, m_stat;

    always #(CLK_P/2) clk = ~clk;

    dbg_event_gate uut (
        .clk(clk), .rst_n(rst_n), .iac_hit_i(iac), .dac_hit_i(dac),
        .dvc_hit_i(dvc), .msr_de_i(de), .reg_we_i(we), .reg_host_i(host),
        .reg_addr_i(addr), .reg_wdata_i(wd), .reg_rdata_o(rdata),
        .dbg_irq_o(irq), .halt_req_o(halt)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [1:0] a);
        case (a)
            2'd0: return {16'h0, m_en, 6'b0, m_ext, m_int};
            2'd1: return {24'h0, m_own};
            2'd2: return {24'h0, m_stat};
            default: return 32'h0;
        endcase
    endfunction

    // One clock: model advances from the inputs applied before the edge
    task automatic tick();
        bit [7:0] hits, swown, live, rec, clr;
        bit acc;
        hits  = {dvc, dac, iac};
        acc   = we && (host || !m_ext);
        swown = m_ext ? m_own : 8'hFF;
        live  = hits & m_en;
        rec   = live & swown & {8{m_int}};
        e_halt = |(live & ~swown);
        e_irq  = de && m_int && (!m_ext || m_own != 0) && |(m_stat & swown);
        clr   = (acc && addr == 2'd2) ? wd[7:0] : 8'h0;
        @(posedge clk);
        m_stat = (m_stat & ~clr) | rec;
        if (acc && addr == 2'd0) begin
            m_int = wd[0]; m_ext = wd[1]; m_en = wd[15:8];
        end
        if (acc && addr == 2'd1) m_own = wd[7:0];
        @(negedge clk);
    endtask

    task automatic check_all(string tag);
        we = 1'b0;
        for (int a = 0; a < 3; a++) begin
            addr = a[1:0];
            #1;
            chk($sformatf("%s read%0d", tag, a), rdata, exp_read(a[1:0]));
        end
        chk({tag, " irq"},  {31'h0, irq},  {31'h0, e_irq});
        chk({tag, " halt"}, {31'h0, halt}, {31'h0, e_halt});
    endtask

    task automatic drive(bit w, bit h, logic [1:0] a, logic [31:0] d,
                         logic [7:0] hv, bit den);
        we = w; host = h; addr = a; wd = d;
        {dvc, dac, iac} = hv; de = den;
    endtask

    task automatic read_at(logic [1:0] a, output logic [31:0] v);
        we = 1'b0; addr = a; #1; v = rdata;
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_all("R1");

        // R9: register layout
        drive(1, 0, 2'd0, 32'hFFFF_FF01, 8'h0, 0); tick();
        read_at(2'd0, v); chk("R9 ctrl layout", v, 32'h0000_FF01);
        drive(1, 0, 2'd1, 32'hFFFF_FF5A, 8'h0, 0); tick();
        read_at(2'd1, v); chk("R9 own layout", v, 32'h0000_005A);
        read_at(2'd3, v); chk("R9 addr3 zero", v, 32'h0);

        // R3: instruction-address hits 0 and 2
        drive(0, 0, 2'd0, 0, 8'b0000_0101, 0); tick();
        read_at(2'd2, v); chk("R3 iac flags", v, 32'h05);
        check_all("R3");
        // R3: disable resource 6, hit 6 then 7
        drive(1, 0, 2'd0, 32'h0000_BF01, 8'h0, 0); tick();
        drive(0, 0, 2'd0, 0, 8'b0100_0000, 0); tick();
        read_at(2'd2, v); chk("R3 disabled ignored", v, 32'h05);
        drive(0, 0, 2'd0, 0, 8'b1000_0000, 0); tick();
        read_at(2'd2, v); chk("R3 dvc flag bit7", v, 32'h85);

        // R4: irq after enabling
        drive(0, 0, 2'd0, 0, 8'h0, 0); tick();
        chk("R4 irq low without de", {31'h0, irq}, 32'h0);
        drive(0, 0, 2'd0, 0, 8'h0, 1); tick();
        chk("R4 irq high", {31'h0, irq}, 32'h1);
        check_all("R4");

        // R8: clear bit0 with simultaneous hit, clear bit2 alone
        drive(1, 0, 2'd2, 32'h05, 8'b0000_0001, 1); tick();
        read_at(2'd2, v); chk("R8 hit wins, clear works", v, 32'h81);
        check_all("R8");

        // R2/R5: both enables off, hits everywhere
        drive(1, 0, 2'd0, 32'h0000_FF00, 8'h0, 1); tick();
        drive(0, 0, 2'd0, 0, 8'hFF, 1); tick();
        read_at(2'd2, v); chk("R2 flags held", v, 32'h81);
        chk("R5 irq off int", {31'h0, irq}, 32'h0);
        chk("R2 no halt", {31'h0, halt}, 32'h0);
        check_all("R2");

        // R6/R7: enter external debug
        drive(1, 0, 2'd0, 32'h0000_FF03, 8'h0, 1); tick();
        drive(1, 0, 2'd0, 32'h0, 8'h0, 1); tick();
        read_at(2'd0, v); chk("R6 sw ctrl write dropped", v, 32'h0000_FF03);
        drive(1, 0, 2'd2, 32'hFF, 8'h0, 1); tick();
        read_at(2'd2, v); chk("R6 sw clear dropped", v, 32'h81);
        drive(1, 1, 2'd1, 32'h0F, 8'h0, 1); tick();
        read_at(2'd1, v); chk("R6 host write taken", v, 32'h0F);
        drive(0, 0, 2'd0, 0, 8'b0001_0010, 1); tick();
        read_at(2'd2, v); chk("R7 sw-owned recorded only", v, 32'h83);
        chk("R7 halt pulse", {31'h0, halt}, 32'h1);
        drive(0, 0, 2'd0, 0, 8'h0, 1); tick();
        chk("R7 halt drops", {31'h0, halt}, 32'h0);
        check_all("R7");
        drive(1, 1, 2'd1, 32'h0, 8'h0, 1); tick();
        drive(0, 0, 2'd0, 0, 8'h0, 1); tick();
        chk("R5 irq off no ownership", {31'h0, irq}, 32'h0);
        check_all("R5");
        drive(1, 1, 2'd0, 32'h0000_FF01, 8'h0, 1); tick();
        check_all("R6");

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] d;
            d = $urandom;
            if ($urandom % 4 != 0) d[0] = 1'b1;
            if ($urandom % 3 != 0) d[1] = 1'b0;
            drive(($urandom % 4) == 0, ($urandom % 4) == 0, 2'($urandom),
                  d, 8'($urandom & $urandom), 1'($urandom));
            tick();
            check_all("R3/R4/R7/R8 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule